// File: doc/BRIEF.md
# Four-Point Cyclic Convolver with Shared Rotated Lookup

The block computes a four-point cyclic convolution of four signed input samples against four coefficients fixed at elaboration time. It uses bit-serial distributed arithmetic: it takes one bit of every sample per cycle, starting at the least significant bit. Those four bits form a plane that addresses a precomputed table of coefficient sums.

Every output uses the same coefficients, with the inputs taken in a rotated order. Because of this, the partial products of all four outputs come from rotations of a single bit plane. A class decoder reduces each plane to one of six seed patterns and a rotation amount. One shared table of 24 words returns all four partial sums of that seed in a single access. A rotator moves those sums into output order, and four shift-accumulators build the results. The bit plane of the sign bit is subtracted instead of added.

A caller presents four samples and pulses `start`. Sixteen cycles later `done` pulses, and the four full-precision results stay on `y_out` until the next accepted start.

Top module: `cda_conv`

## Requirements
- R1: After reset, `done` is 0 and all four result fields of `y_out` are 0.
- R2: A start accepted while idle captures `x_in`, where sample x[n] sits in bits [16n+15:16n]. The block then produces y[k] = sum over n of x[n]*h[(k-n) mod 4], with all values in two's complement. Result y[k] sits in bits [34k+33:34k] of `y_out`.
- R3: Each of the 16 possible bit planes maps to one of six seeds (0000, 0001, 0011, 0101, 0111, 1111) and a rotation r such that rotating the seed left by r gives back the plane. The seed and rotation select the correct partial sum for every output.
- R4: `done` rises on the 16th rising clock edge after the edge that accepted the start.
- R5: `done` stays high for exactly one cycle per accepted start.
- R6: The sign-bit plane is subtracted, so inputs of -32768 give exact results, including the extreme value 2^32.
- R7: A start that arrives while a computation is running is ignored. The running result is unchanged and no extra `done` pulse appears.
- R8: After `done`, the results on `y_out` hold steady until the next start is accepted.
- R9: A start asserted in the same cycle that `done` is high is accepted, so computations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a computation when the block is idle |
| x_in | input | 64 | Four 16-bit signed samples, x[0] in the low bits |
| y_out | output | 136 | Four 34-bit signed results, y[0] in the low bits |
| done | output | 1 | One-cycle pulse when the results are ready |

## Verification
The hardest situation to reach from the ports is a second start arriving partway through a computation, with different sample values. If the block obeyed that start, the error would show up only in the result values. The bench raises start with fresh data in the middle of a run, then checks that the scoreboard still matches the original vector and that no unexpected completion appears. The rotation classes are covered with single-sample impulses at different positions, and the sign-plane subtraction with all-minimum and alternating-extreme vectors. Back-to-back runs start in the same cycle that `done` is high.

// File: rtl/cda_pkg.sv
package cda_pkg;
   localparam int CLASSES = 6;
   localparam int PTS     = 4;

   // seed pattern of each rotation class
   function automatic logic [3:0] seed_pat(input int g);
      case (g)
         0:       return 4'b0000;
         1:       return 4'b0001;
         2:       return 4'b0011;
         3:       return 4'b0101;
         4:       return 4'b0111;
         default: return 4'b1111;
      endcase
   endfunction

   // res[i] = p[i - r]
   function automatic logic [3:0] rotl4(input logic [3:0] p, input int r);
      logic [3:0] res;
      for (int i = 0; i < PTS; i++) res[i] = p[(i - r + PTS) % PTS];
      return res;
   endfunction

   // res[i] = p[i + r]
   function automatic logic [3:0] rotr4(input logic [3:0] p, input int r);
      logic [3:0] res;
      for (int i = 0; i < PTS; i++) res[i] = p[(i + r) % PTS];
      return res;
   endfunction
endpackage

// File: rtl/cda_class_dec.sv
module cda_class_dec #(
   parameter int N_PTS = 4,
   parameter int GW    = 3,
   parameter int RW    = 2
) (
   input  logic [N_PTS-1:0] plane,
   output logic [GW-1:0]    grp,
   output logic [RW-1:0]    rot
);
   // search descending so the smallest matching rotation wins
   always_comb begin
      grp = '0;
      rot = '0;
      for (int r = N_PTS - 1; r >= 0; r--) begin
         for (int g = 0; g < cda_pkg::CLASSES; g++) begin
            if (cda_pkg::rotr4(plane, r) == cda_pkg::seed_pat(g)) begin
               grp = GW'(g);
               rot = RW'(r);
            end
         end
      end
   end
endmodule

// File: rtl/cda_group_rom.sv
module cda_group_rom #(
   parameter int N_PTS = 4,
   parameter int W     = 16,
   parameter int PW    = 18,
   parameter int GW    = 3,
   parameter logic [N_PTS*W-1:0] COEF = '0
) (
   input  logic [GW-1:0]                 grp,
   output logic [N_PTS-1:0][PW-1:0]      words
);
   localparam int DEPTH = cda_pkg::CLASSES * N_PTS;

   // word j of class g: partial sum feeding output j when the plane equals the seed
   function automatic logic [PW-1:0] rom_word(input int g, input int j);
      logic [3:0]   s;
      logic [W-1:0] c;
      logic [PW-1:0] sum;
      s   = cda_pkg::seed_pat(g);
      sum = '0;
      for (int n = 0; n < N_PTS; n++) begin
         if (s[n]) begin
            c   = COEF[((j - n + N_PTS) % N_PTS) * W +: W];
            sum = sum + {{(PW-W){c[W-1]}}, c};
         end
      end
      return sum;
   endfunction

   logic [PW-1:0] tab [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_tab
      assign tab[i] = rom_word(i / N_PTS, i % N_PTS);
   end

   for (genvar j = 0; j < N_PTS; j++) begin : g_rd
      assign words[j] = tab[int'(grp) * N_PTS + j];
   end
endmodule

// File: rtl/cda_rotator.sv
module cda_rotator #(
   parameter int N_PTS = 4,
   parameter int PW    = 18,
   parameter int RW    = 2
) (
   input  logic [N_PTS-1:0][PW-1:0] din,
   input  logic [RW-1:0]            rot,
   output logic [N_PTS-1:0][PW-1:0] dout
);
   // output k takes seed word (k - rot) mod N
   for (genvar k = 0; k < N_PTS; k++) begin : g_k
      logic [RW-1:0] idx;
      assign idx     = RW'(k) - rot;
      assign dout[k] = din[idx];
   end
endmodule

// File: rtl/cda_shift_acc.sv
module cda_shift_acc #(
   parameter int W  = 16,
   parameter int PW = 18,
   parameter int AW = 34
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 en,
   input  logic                 neg,
   input  logic [PW-1:0]        pp,
   output logic signed [AW-1:0] acc
);
   logic signed [AW-1:0] ext, shl, addend;

   always_comb begin
      ext    = {{(AW-PW){pp[PW-1]}}, pp};
      shl    = ext <<< (W - 1);
      addend = neg ? -shl : shl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc <= '0;
      else if (clr) acc <= '0;
      else if (en)  acc <= (acc >>> 1) + addend;
   end
endmodule

// File: rtl/cda_conv.sv
module cda_conv #(
   parameter int N_PTS = 4,
   parameter int W     = 16,
   parameter logic [N_PTS*W-1:0] COEF = {16'h8000, 16'h7FFF, 16'hA460, 16'h3039}
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [N_PTS*W-1:0]       x_in,
   output logic [N_PTS*(2*W+2)-1:0] y_out,
   output logic                     done
);
   localparam int AW = 2 * W + 2;
   localparam int PW = W + 2;
   localparam int BW = $clog2(W);
   localparam int GW = $clog2(cda_pkg::CLASSES);
   localparam int RW = $clog2(N_PTS);

   initial begin
      assert (N_PTS == cda_pkg::PTS) else $error("cda_conv: N_PTS must be 4");
      assert (W >= 2) else $error("cda_conv: W must be at least 2");
   end

   logic                      busy;
   logic [BW-1:0]             bit_idx;
   logic [W-1:0]              xr [N_PTS];
   logic [N_PTS-1:0]          plane;
   logic [GW-1:0]             grp;
   logic [RW-1:0]             rot;
   logic [N_PTS-1:0][PW-1:0]  gwords, owords;
   logic                      accept, last;

   assign accept = start && !busy;
   assign last   = (bit_idx == BW'(W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         bit_idx <= '0;
         done    <= 1'b0;
         for (int n = 0; n < N_PTS; n++) xr[n] <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy    <= 1'b1;
            bit_idx <= '0;
            for (int n = 0; n < N_PTS; n++) xr[n] <= x_in[n*W +: W];
         end else if (busy) begin
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               bit_idx <= bit_idx + 1'b1;
            end
         end
      end
   end

   for (genvar n = 0; n < N_PTS; n++) begin : g_plane
      assign plane[n] = xr[n][bit_idx];
   end

   cda_class_dec #(.N_PTS(N_PTS), .GW(GW), .RW(RW)) u_dec (
      .plane(plane), .grp(grp), .rot(rot));

   cda_group_rom #(.N_PTS(N_PTS), .W(W), .PW(PW), .GW(GW), .COEF(COEF)) u_rom (
      .grp(grp), .words(gwords));

   cda_rotator #(.N_PTS(N_PTS), .PW(PW), .RW(RW)) u_rot (
      .din(gwords), .rot(rot), .dout(owords));

   for (genvar k = 0; k < N_PTS; k++) begin : g_acc
      logic signed [AW-1:0] acc;
      cda_shift_acc #(.W(W), .PW(PW), .AW(AW)) u_acc (
         .clk(clk), .rst_n(rst_n), .clr(accept), .en(busy),
         .neg(last), .pp(owords[k]), .acc(acc));
      assign y_out[k*AW +: AW] = acc;
   end
endmodule

// File: rtl/cda_conv_chk.sv
module cda_conv_chk #(
   parameter int N_PTS = 4,
   parameter int W     = 16,
   parameter int AW    = 34,
   parameter int BW    = 4,
   parameter int GW    = 3,
   parameter int RW    = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 busy,
   input logic [BW-1:0]        bit_idx,
   input logic                 done,
   input logic [N_PTS*AW-1:0]  y_out,
   input logic [N_PTS-1:0]     plane,
   input logic [GW-1:0]        grp,
   input logic [RW-1:0]        rot
);
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r4_done_after_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && $past(bit_idx) == BW'(W - 1)));

   a_r7_run_not_restarted: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bit_idx != BW'(W - 1)) |=> (busy && bit_idx == $past(bit_idx) + 1'b1));

   a_r8_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> $stable(y_out));

   a_r3_class_rotation: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(grp) < cda_pkg::CLASSES) &&
      (cda_pkg::rotl4(cda_pkg::seed_pat(int'(grp)), int'(rot)) == plane));
endmodule

bind cda_conv cda_conv_chk #(
   .N_PTS(N_PTS), .W(W), .AW(AW), .BW(BW), .GW(GW), .RW(RW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .bit_idx(bit_idx), .done(done),
   .y_out(y_out), .plane(plane), .grp(grp), .rot(rot)
);

// File: tb/cda_conv_tb_top.sv
module cda_conv_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 4;
   localparam int W  = 16;
   localparam int AW = 2 * W + 2;
   localparam logic signed [W-1:0] H0 = 16'sd12345;
   localparam logic signed [W-1:0] H1 = -16'sd23456;
   localparam logic signed [W-1:0] H2 = 16'sd32767;
   localparam logic signed [W-1:0] H3 = -16'sd32768;

   typedef struct packed {
      longint y3, y2, y1, y0;
      int     t0;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [N*W-1:0]    x_in = '0;
   logic [N*AW-1:0]   y_out;
   logic              done;

   int     checks = 0;
   int     errors = 0;
   int     cyc = 0;
   item_t  exp_q[$];
   item_t  last_item;
   logic   done_prev = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cda_conv #(.N_PTS(N), .W(W), .COEF({H3, H2, H1, H0})) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
      .y_out(y_out), .done(done));

   function automatic longint coef(input int i);
      case (i)
         0: return longint'(H0);
         1: return longint'(H1);
         2: return longint'(H2);
         default: return longint'(H3);
      endcase
   endfunction

   function automatic longint ysel(input item_t it, input int k);
      case (k)
         0: return it.y0;
         1: return it.y1;
         2: return it.y2;
         default: return it.y3;
      endcase
   endfunction

   function automatic longint yact(input int k);
      logic signed [AW-1:0] v;
      v = y_out[k*AW +: AW];
      return longint'(v);
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // expected result from direct multiply-accumulate
   function automatic item_t model(input logic [N*W-1:0] xv);
      item_t  it;
      longint s [N];
      for (int k = 0; k < N; k++) begin
         s[k] = 0;
         for (int n = 0; n < N; n++) begin
            logic signed [W-1:0] xs;
            xs   = xv[n*W +: W];
            s[k] += longint'(xs) * coef((k - n + N) % N);
         end
      end
      it.y0 = s[0]; it.y1 = s[1]; it.y2 = s[2]; it.y3 = s[3];
      it.t0 = 0;
      return it;
   endfunction

   // driver: pulses start; if poke is set, a second start with other data is raised mid-run (R7)
   task automatic run_vec(input logic [N*W-1:0] xv, input bit poke);
      item_t it;
      @(negedge clk);
      x_in  = xv;
      start = 1'b1;
      it    = model(xv);
      it.t0 = cyc;
      exp_q.push_back(it);
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (4) @(negedge clk);
         x_in  = ~xv;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (10) @(negedge clk);
      end else begin
         repeat (15) @(negedge clk);
      end
   endtask

   // monitor: pops the scoreboard on each done pulse
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            chk(!done_prev, "R5 done single pulse", 1, 0);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7 unexpected done", 1, 0);
            end else begin
               item_t it;
               it = exp_q.pop_front();
               last_item = it;
               chk((cyc - it.t0) == 17, "R4 latency", longint'(cyc - it.t0), 17);
               for (int k = 0; k < N; k++)
                  chk(yact(k) == ysel(it, k), "R2 R3 R6 result", yact(k), ysel(it, k));
            end
         end
         done_prev <= done;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(done == 1'b0, "R1 done after reset", longint'(done), 0);
      for (int k = 0; k < N; k++) chk(yact(k) == 0, "R1 y after reset", yact(k), 0);

      // R2 R3 directed patterns, issued back to back (R9)
      run_vec({16'sd0, 16'sd0, 16'sd0, 16'sd0}, 1'b0);
      run_vec({16'sd0, 16'sd0, 16'sd0, 16'sd1}, 1'b0);
      run_vec({16'sd0, 16'sd1, 16'sd0, 16'sd0}, 1'b0);
      run_vec({16'sd0, 16'sd0, 16'sd5, -16'sd3}, 1'b0);
      // R6 sign-plane extremes
      run_vec({-16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768}, 1'b0);
      run_vec({16'sd32767, 16'sd32767, 16'sd32767, 16'sd32767}, 1'b0);
      run_vec({16'sd32767, -16'sd32768, 16'sd32767, -16'sd32768}, 1'b0);
      run_vec({-16'sd1, -16'sd1, -16'sd1, -16'sd1}, 1'b0);
      // R3 random planes
      for (int i = 0; i < 12; i++)
         run_vec({16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom)}, 1'b0);
      // R7 start while busy is ignored
      run_vec({16'sd1000, -16'sd2000, 16'sd3000, -16'sd4000}, 1'b1);

      // R8 results hold while idle
      repeat (6) @(negedge clk);
      for (int k = 0; k < N; k++)
         chk(yact(k) == ysel(last_item, k), "R8 hold after done", yact(k), ysel(last_item, k));
      chk(exp_q.size() == 0, "R7 scoreboard drained", longint'(exp_q.size()), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule